// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block divides a VCO-rate clock by a programmable integer N and, through a small fractional accumulator, stretches chosen divider cycles to N+1 input cycles so that the long-run ratio becomes N plus a fraction. The fraction is NF/Q. The increment NF is three bits wide. The modulus Q is either eight or five, chosen by a single bit. Every completed divider cycle ends with a one-clock pulse toward the phase detector. That same pulse adds NF to the accumulator, and an overflow lengthens the following cycle by one input clock.

Each pulse also opens a fixed-width compensation window. During that window the accumulator value is held steady, so a downstream current DAC can scale its correction pulse by it. New ratio words can be written at any time through a load strobe. They are staged and only come into force when the running divider cycle finishes, so the output phase never jumps mid-cycle. Dropping the enable clears the count and the accumulator. Raising it again starts a fresh cycle from its first input clock, which keeps the divider aligned with the reference side.

Top module: `fracn_main_div`

## Requirements
- R1: After reset, div_pulse, comp_win, nf_bad and acc_val are all 0. The active and staged ratio words are N = N_MIN, NF = 0 and modulus 8.
- R2: While en is high, div_pulse is high for exactly one input cycle at the end of each divider cycle. A divider cycle normally lasts N input cycles, and the first pulse after enabling falls in the N-th enabled cycle.
- R3: At each div_pulse the accumulator becomes (acc + NF') mod Q, where NF' = NF mod Q. The modulus bit selects Q: 0 gives Q = 8 and 1 gives Q = 5. Between pulses acc_val does not change.
- R4: A pulse whose addition reaches or exceeds Q makes the next divider cycle last N+1 input cycles. Over Q cycles the span is Q*N + NF'.
- R5: An N below N_MIN (512 by default) divides as N_MIN.
- R6: load captures n_in, nf_in and mod5_in into a staging register. A value loaded mid-cycle affects neither the running cycle's length nor the accumulator until the next pulse. At that pulse it sets the next cycle's length, and its NF and modulus are the ones used in that pulse's accumulation.
- R7: A load made in the same cycle as div_pulse takes effect at that same boundary.
- R8: comp_win is high for exactly WIN_LEN (128 by default) input cycles, starting the cycle after each div_pulse. acc_val stays constant while it is high.
- R9: nf_bad is high exactly when the active word selects modulus 5 and has NF >= 5. Such an NF is used reduced modulo 5.
- R10: While en is low, div_pulse is never high. From the next cycle on, acc_val is 0 and comp_win is 0, and staged words become active immediately.
- R11: When en rises, counting restarts from the start of a cycle with the accumulator at 0. The first pulse falls in the N-th cycle of enable, using the word active at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider enable; low holds the divider idle and cleared |
| load | input | 1 | Captures a new ratio word into staging |
| n_in | input | 16 | Integer ratio N |
| nf_in | input | 3 | Fractional increment NF |
| mod5_in | input | 1 | Modulus select: 0 for 8, 1 for 5 |
| div_pulse | output | 1 | One-cycle end-of-divider-cycle pulse |
| acc_val | output | 3 | Present fractional accumulator value |
| comp_win | output | 1 | Compensation window, WIN_LEN cycles after each pulse |
| nf_bad | output | 1 | Active NF is out of range for modulus 5 |

## Verification
Two events can land in the same input cycle: a ratio load and the divider boundary, where the staged word is promoted and the accumulator steps. The bench provokes this by counting to the exact cycle of a known pulse and raising load in it. It first confirms the pulse is visible in that cycle. It then judges by the next pulse's position that the new N governed the very next cycle. A second case loads mid-cycle and expects the old length to finish first. A modulus change from 8 to 5 while the accumulator holds 7 checks that the step taken at the boundary uses the new modulus.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int N_W   = 16;
  localparam int NF_W  = 3;
  localparam int ACC_W = 3;
  localparam int SUM_W = ACC_W + 2;

  typedef struct packed {
    logic [N_W-1:0]  n;
    logic [NF_W-1:0] nf;
    logic            mod5;
  } ratio_t;

  typedef struct packed {
    logic             ovf;
    logic [ACC_W-1:0] nxt;
  } step_t;

  // Modulus Q selected by the mode bit.
  function automatic logic [SUM_W-1:0] modulus(input logic mod5);
    return mod5 ? SUM_W'(5) : SUM_W'(8);
  endfunction

  // NF reduced into 0..Q-1 (one subtraction suffices since NF < 8 <= 2Q).
  function automatic logic [NF_W-1:0] nf_reduce(input logic [NF_W-1:0] nf,
                                                input logic mod5);
    logic [SUM_W-1:0] q;
    logic [SUM_W-1:0] d;
    q = modulus(mod5);
    d = SUM_W'(nf) - q;
    if (SUM_W'(nf) >= q) return d[NF_W-1:0];
    return nf;
  endfunction

  function automatic logic nf_invalid(input logic [NF_W-1:0] nf,
                                      input logic mod5);
    return SUM_W'(nf) >= modulus(mod5);
  endfunction

  // One accumulation step; the old value may exceed a freshly selected
  // modulus, so up to two subtractions of Q are needed.
  function automatic step_t frac_step(input logic [ACC_W-1:0] acc,
                                      input logic [NF_W-1:0]  nf,
                                      input logic             mod5);
    logic [SUM_W-1:0] q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] d;
    step_t r;
    q   = modulus(mod5);
    sum = SUM_W'(acc) + SUM_W'(nf_reduce(nf, mod5));
    if (sum >= (q << 1)) begin
      d     = sum - (q << 1);
      r.ovf = 1'b1;
    end else if (sum >= q) begin
      d     = sum - q;
      r.ovf = 1'b1;
    end else begin
      d     = sum;
      r.ovf = 1'b0;
    end
    r.nxt = d[ACC_W-1:0];
    return r;
  endfunction

  function automatic logic [N_W-1:0] clamp_n(input logic [N_W-1:0] n,
                                             input logic [N_W-1:0] nmin);
    return (n < nmin) ? nmin : n;
  endfunction

endpackage

// File: rtl/fracn_ratio_reg.sv
module fracn_ratio_reg
  import fracn_pkg::*;
#(
  parameter int N_MIN = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [N_W-1:0]  n_in,
  input  logic [NF_W-1:0] nf_in,
  input  logic            mod5_in,
  input  logic            apply,
  output ratio_t          incoming_o,
  output ratio_t          act_o
);

  localparam ratio_t RST_WORD = '{n: N_W'(N_MIN), nf: '0, mod5: 1'b0};

  ratio_t stg_q;
  ratio_t act_q;
  ratio_t incoming;

  // A load in the current cycle bypasses the staging register.
  assign incoming = load ? '{n: n_in, nf: nf_in, mod5: mod5_in} : stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= RST_WORD;
      act_q <= RST_WORD;
    end else begin
      stg_q <= incoming;
      if (apply) act_q <= incoming;
    end
  end

  assign incoming_o = incoming;
  assign act_o      = act_q;

endmodule

// File: rtl/fracn_cycle_cnt.sv
module fracn_cycle_cnt
  import fracn_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N_W-1:0] eff_n,
  input  logic           stretch,
  output logic           pulse
);

  logic [N_W-1:0] cnt_q;
  logic [N_W-1:0] last_idx;

  assign last_idx = eff_n - N_W'(1) + {{(N_W-1){1'b0}}, stretch};
  assign pulse    = en && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (pulse)  cnt_q <= '0;
    else             cnt_q <= cnt_q + N_W'(1);
  end

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pulse,
  input  logic [NF_W-1:0]  nf_next,
  input  logic             mod5_next,
  output logic [ACC_W-1:0] acc_o,
  output logic             stretch_o
);

  step_t step;
  logic [ACC_W-1:0] acc_q;
  logic             stretch_q;

  assign step = frac_step(acc_q, nf_next, mod5_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (!en) begin
      acc_q     <= '0;
      stretch_q <= 1'b0;
    end else if (pulse) begin
      acc_q     <= step.nxt;
      stretch_q <= step.ovf;
    end
  end

  assign acc_o     = acc_q;
  assign stretch_o = stretch_q;

endmodule

// File: rtl/fracn_comp_win.sv
module fracn_comp_win #(
  parameter int WIN_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse,
  output logic win
);

  localparam int WC_W = $clog2(WIN_LEN + 1);

  logic [WC_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (!en)            left_q <= '0;
    else if (pulse)          left_q <= WC_W'(WIN_LEN);
    else if (left_q != '0)   left_q <= left_q - WC_W'(1);
  end

  assign win = (left_q != '0);

endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
  import fracn_pkg::*;
#(
  parameter int N_MIN   = 512,
  parameter int WIN_LEN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [N_W-1:0]   n_in,
  input  logic [NF_W-1:0]  nf_in,
  input  logic             mod5_in,
  output logic             div_pulse,
  output logic [ACC_W-1:0] acc_val,
  output logic             comp_win,
  output logic             nf_bad
);

  ratio_t          incoming;
  ratio_t          act;
  logic            apply;
  logic            stretch;
  logic [N_W-1:0]  eff_n;
  // Named internal events for the bound checker.
  logic [N_W-1:0]  act_n;
  logic            act_mod5;

  assign apply    = div_pulse || !en;
  assign eff_n    = clamp_n(act.n, N_W'(N_MIN));
  assign act_n    = act.n;
  assign act_mod5 = act.mod5;
  assign nf_bad   = nf_invalid(act.nf, act.mod5);

  fracn_ratio_reg #(.N_MIN(N_MIN)) u_ratio (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .n_in       (n_in),
    .nf_in      (nf_in),
    .mod5_in    (mod5_in),
    .apply      (apply),
    .incoming_o (incoming),
    .act_o      (act)
  );

  fracn_cycle_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .eff_n   (eff_n),
    .stretch (stretch),
    .pulse   (div_pulse)
  );

  fracn_accum u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pulse     (div_pulse),
    .nf_next   (incoming.nf),
    .mod5_next (incoming.mod5),
    .acc_o     (acc_val),
    .stretch_o (stretch)
  );

  fracn_comp_win #(.WIN_LEN(WIN_LEN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .pulse (div_pulse),
    .win   (comp_win)
  );

endmodule

// File: rtl/fracn_main_div_chk.sv
module fracn_main_div_chk
  import fracn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             div_pulse,
  input logic             comp_win,
  input logic [ACC_W-1:0] acc_val,
  input logic             nf_bad,
  input logic [N_W-1:0]   act_n,
  input logic             act_mod5
);

  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !div_pulse);

  assert_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc_val == '0) && !comp_win);

  assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !div_pulse) |=> $stable(acc_val));

  assert_acc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mod5 && $past(div_pulse)) |-> (acc_val < ACC_W'(5)));

  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !div_pulse) |=> $stable(act_n));

  assert_win_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> comp_win);

  assert_win_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_win && $past(comp_win)) |-> $stable(acc_val));

  assert_flag_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nf_bad |-> act_mod5);

endmodule

bind fracn_main_div fracn_main_div_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .div_pulse (div_pulse),
  .comp_win  (comp_win),
  .acc_val   (acc_val),
  .nf_bad    (nf_bad),
  .act_n     (act_n),
  .act_mod5  (act_mod5)
);

// File: tb/sim_fracn_main_div.sv
module sim_fracn_main_div;

  localparam int NMIN = 16;
  localparam int WL   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [15:0] n_in = '0;
  logic [2:0]  nf_in = '0;
  logic        mod5_in = 1'b0;
  logic        div_pulse;
  logic [2:0]  acc_val;
  logic        comp_win;
  logic        nf_bad;

  always #5 clk = ~clk;

  fracn_main_div #(.N_MIN(NMIN), .WIN_LEN(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .n_in(n_in),
    .nf_in(nf_in), .mod5_in(mod5_in), .div_pulse(div_pulse),
    .acc_val(acc_val), .comp_win(comp_win), .nf_bad(nf_bad)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference state derived from the requirements.
  int m_n = NMIN, m_nf = 0, m_md = 0;
  int s_n = NMIN, s_nf = 0, s_md = 0;
  int m_acc = 0, m_rem = NMIN, m_win = 0;
  int pidx [0:15];
  int np;

  function automatic int effn(int n);
    return (n < NMIN) ? NMIN : n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One input cycle: drive, sample away from the edge, advance the model.
  task automatic cyc(bit e, bit ld, int n, int nf, bit md);
    bit exp_p;
    int in_n, in_nf, in_md, q, sum;
    @(negedge clk);
    en = e; load = ld; n_in = n[15:0]; nf_in = nf[2:0]; mod5_in = md;
    #1;
    exp_p = e && (m_rem == 1);
    chk(div_pulse == exp_p, "R2 pulse position", int'(div_pulse), int'(exp_p));
    chk(int'(acc_val) == m_acc, "R3 accumulator", int'(acc_val), m_acc);
    chk(comp_win == (m_win > 0), "R8 window", int'(comp_win), int'(m_win > 0));
    chk(nf_bad == (m_md == 1 && m_nf >= 5), "R9 flag", int'(nf_bad),
        int'(m_md == 1 && m_nf >= 5));
    in_n  = ld ? n  : s_n;
    in_nf = ld ? nf : s_nf;
    in_md = ld ? int'(md) : s_md;
    if (!e) begin
      m_acc = 0; m_win = 0;
      m_n = in_n; m_nf = in_nf; m_md = in_md;
      m_rem = effn(in_n);
    end else if (exp_p) begin
      q     = (in_md == 1) ? 5 : 8;
      sum   = m_acc + (in_nf % q);
      m_acc = sum % q;
      m_rem = effn(in_n) + ((sum >= q) ? 1 : 0);
      m_win = WL;
      m_n = in_n; m_nf = in_nf; m_md = in_md;
    end else begin
      m_rem--;
      if (m_win > 0) m_win--;
    end
    s_n = in_n; s_nf = in_nf; s_md = in_md;
  endtask

  task automatic cfg(int n, int nf, bit md);
    cyc(1'b0, 1'b1, n, nf, md);
    cyc(1'b0, 1'b0, n, nf, md);
  endtask

  task automatic play(int cycles, int ld_at, int ln, int lnf, bit lmd);
    np = 0;
    for (int i = 0; i < 16; i++) pidx[i] = -1;
    for (int i = 0; i < cycles; i++) begin
      cyc(1'b1, i == ld_at, ln, lnf, lmd);
      if (div_pulse && np < 16) begin
        pidx[np] = i;
        np++;
      end
    end
  endtask

  task automatic off(int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int sweep_n [0:2];
    sweep_n[0] = 16; sweep_n[1] = 19; sweep_n[2] = 33;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(div_pulse == 1'b0, "R1 reset pulse", int'(div_pulse), 0);
    chk(comp_win == 1'b0, "R1 reset window", int'(comp_win), 0);
    chk(acc_val == 3'd0, "R1 reset acc", int'(acc_val), 0);
    chk(nf_bad == 1'b0, "R1 reset flag", int'(nf_bad), 0);
    @(negedge clk);
    rst_n = 1'b1;
    off(2);

    // R2/R3/R4/R8/R9 sweep over modulus, NF and N
    for (int md = 0; md < 2; md++) begin
      for (int nf = 0; nf < 8; nf++) begin
        for (int k = 0; k < 3; k++) begin
          int cnt = 0;
          int g   = 0;
          cfg(sweep_n[k], nf, md[0]);
          while (cnt < 12 && g < 2000) begin
            cyc(1'b1, 1'b0, 0, 0, 1'b0);
            if (div_pulse) cnt++;
            g++;
          end
          chk(cnt == 12, "R2 pulse count", cnt, 12);
          off(3);
        end
      end
    end

    // R4 NF=2 modulo 5: stretched cycles and average span
    cfg(20, 2, 1'b1);
    play(130, -1, 0, 0, 1'b0);
    chk(pidx[0] == 19, "R2 first pulse", pidx[0], 19);
    chk(pidx[3] - pidx[2] == 21, "R4 stretched cycle", pidx[3] - pidx[2], 21);
    chk(pidx[2] - pidx[1] == 20, "R4 plain cycle", pidx[2] - pidx[1], 20);
    chk(pidx[5] - pidx[0] == 102, "R4 span over Q", pidx[5] - pidx[0], 102);
    off(2);

    // R5 ratio below minimum
    cfg(3, 0, 1'b0);
    play(40, -1, 0, 0, 1'b0);
    chk(pidx[0] == NMIN - 1, "R5 clamp first", pidx[0], NMIN - 1);
    chk(pidx[1] == 2 * NMIN - 1, "R5 clamp second", pidx[1], 2 * NMIN - 1);
    off(2);

    // R6 mid-cycle reload
    cfg(20, 0, 1'b0);
    play(60, 5, 30, 0, 1'b0);
    chk(pidx[0] == 19, "R6 old length kept", pidx[0], 19);
    chk(pidx[1] == 49, "R6 new length next", pidx[1], 49);
    off(2);

    // R7 load coinciding with the boundary
    cfg(20, 0, 1'b0);
    play(50, 19, 25, 0, 1'b0);
    chk(pidx[0] == 19, "R7 collision pulse seen", pidx[0], 19);
    chk(pidx[1] == 44, "R7 new length at boundary", pidx[1], 44);
    off(2);

    // R3 modulus switch while accumulator holds 7
    cfg(20, 7, 1'b0);
    play(70, 25, 20, 1, 1'b1);
    chk(pidx[1] == 39, "R3 switch pulse", pidx[1], 39);
    chk(pidx[2] == 60, "R3 switch overflow", pidx[2], 60);
    off(2);

    // R9 out-of-range NF under modulo 5
    cfg(20, 6, 1'b1);
    chk(nf_bad == 1'b1, "R9 flag raised", int'(nf_bad), 1);
    play(45, -1, 0, 0, 1'b0);
    off(2);

    // R10 disable inside the window, R11 restart
    cfg(20, 1, 1'b0);
    play(22, -1, 0, 0, 1'b0);
    off(1);
    cyc(1'b0, 1'b0, 0, 0, 1'b0);
    chk(acc_val == 3'd0, "R10 acc cleared", int'(acc_val), 0);
    chk(comp_win == 1'b0, "R10 window cleared", int'(comp_win), 0);
    cyc(1'b0, 1'b1, 18, 1, 1'b0);
    off(1);
    play(40, -1, 0, 0, 1'b0);
    chk(pidx[0] == 17, "R11 restart first pulse", pidx[0], 17);
    chk(pidx[1] == 35, "R11 restart second pulse", pidx[1], 35);
    off(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule